// File: doc/BRIEF.md
# Page Write Merge Sequencer

This block turns a stream of host bytes into a byte-alterable update of one page held in an array that can only be erased as a whole page and programmed bit-downward. A command opens with a start strobe carrying a mode and a byte address. The page-offset part of the address selects the first buffer slot. Each following data strobe stores one byte and moves the slot pointer forward, wrapping within the page. The command closes with an end strobe, which stands for chip select going high. A write enable strobe, given while idle, arms the block for one command.

In rewrite mode, the end strobe starts an internal cycle with three phases. First, every slot the host did not touch is filled from the array copy of the page. Next, the page is erased to all ones. Last, the whole buffer is programmed back. In program-only mode, the read and erase phases are skipped. Untouched slots are driven as all ones, so the array keeps the old value ANDed with the new one. A busy flag covers the whole internal cycle. The cycle ends with a one-cycle done pulse, which also drops the write enable.

Top module: `pw_merge_seq`

## Requirements
- R1: After reset, wip_o, wel_o and done_o are 0 and no array strobe (read, erase, write) is driven.
- R2: A wren_i pulse while idle sets wel_o. A command started while wel_o is 0 is ignored: wip_o stays 0 and the array is not touched.
- R3: The k-th data byte (k counting from 0) goes to page offset (A[7:0] + k) mod 256 of the page A[23:8]. When several bytes land on the same offset, the last one wins.
- R4: The internal cycle starts only on an end strobe that follows at least one data byte. An end strobe with no data returns the block to idle, with no array activity and wel_o unchanged.
- R5: In rewrite mode (cmd_pp_i=0), page bytes the host did not supply keep their old array value. Exactly 256 merge reads are issued.
- R6: In rewrite mode, supplied bytes take their new value even where bits go from 0 to 1. The sequence is one page erase followed by 256 byte writes.
- R7: In program-only mode (cmd_pp_i=1), no erase and no read is issued. Each supplied byte becomes old AND new, and all other bytes are unchanged.
- R8: wip_o rises in the cycle after the accepted end strobe and is 1 whenever an array strobe is driven. It stays 1 for exactly 2*(PAGE_BYTES+1)+1+ERASE_CYCLES+PROG_CYCLES cycles in rewrite mode, and for PAGE_BYTES+1+PROG_CYCLES cycles in program-only mode.
- R9: done_o is a single-cycle pulse in the first cycle with wip_o low. wel_o is 0 from that cycle on.
- R10: A data byte that arrives in the same cycle as the end strobe is included in the page update.
- R11: Data bytes, start strobes and wren_i pulses that arrive while idle (bytes) or while busy (all three) have no effect on the page or on wel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wren_i | input | 1 | Write enable strobe |
| cmd_start_i | input | 1 | Command open strobe |
| cmd_pp_i | input | 1 | Mode at open: 0 rewrite, 1 program-only |
| cmd_addr_i | input | ADDR_W | Byte address at open |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| cmd_end_i | input | 1 | Command close strobe (chip select high) |
| wip_o | output | 1 | Internal cycle in progress |
| wel_o | output | 1 | Write enable latch |
| done_o | output | 1 | End-of-sequence pulse |
| arr_addr_o | output | ADDR_W | Array byte address; page base during erase |
| arr_rd_en_o | output | 1 | Array read strobe; data is returned one cycle later |
| arr_rd_data_i | input | 8 | Array read data |
| arr_erase_o | output | 1 | Page erase strobe |
| arr_wr_en_o | output | 1 | Array program strobe (clears bits only) |
| arr_wr_data_o | output | 8 | Array program data |

## Verification
Two events can fall in the same cycle: the final data byte and the end strobe. The bench raises both in one cycle and then checks that the byte shows up in the page. A second overlap is host traffic arriving while an internal cycle is running. Start strobes, write enable pulses and data bytes are driven during the merge phase, and the bench then checks that the page content and the write enable latch are exactly those produced by the earlier command alone. The array model in the bench erases pages and ANDs programmed bytes. Page contents are compared against an expectation that the bench builds from R3, R5, R6 and R7.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FILL   = 3'd1,
        ST_MERGE  = 3'd2,
        ST_ERASE  = 3'd3,
        ST_EWAIT  = 3'd4,
        ST_PROG   = 3'd5,
        ST_PWAIT  = 3'd6,
        ST_FINISH = 3'd7
    } seq_st_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/pwm_page_buf.sv
module pwm_page_buf
    import pwm_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             hw_en_i,
    input  logic [IDX_W-1:0] hw_idx_i,
    input  logic [7:0]       hw_data_i,
    input  logic             mw_en_i,
    input  logic [IDX_W-1:0] mw_idx_i,
    input  logic [7:0]       mw_data_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [7:0]       rd_data_o
);

    logic [7:0]       slot_q [DEPTH];
    logic [DEPTH-1:0] vld_d, vld_q;

    // Host bytes always win; merge bytes only fill slots the host left empty.
    always_comb begin
        vld_d = vld_q;
        if (clr_i) begin
            vld_d = '0;
        end else begin
            if (hw_en_i) vld_d[hw_idx_i] = 1'b1;
            if (mw_en_i) vld_d[mw_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (hw_en_i) begin
            slot_q[hw_idx_i] <= hw_data_i;
        end else if (mw_en_i && !vld_q[mw_idx_i]) begin
            slot_q[mw_idx_i] <= mw_data_i;
        end
    end

    // Empty slots read as erased so that programming them changes nothing.
    assign rd_data_o = vld_q[rd_idx_i] ? slot_q[rd_idx_i] : ERASED_BYTE;

endmodule

// File: rtl/pwm_cycle_timer.sv
module pwm_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)              cnt_d = load_val_i;
        else if (cnt_q != '0)    cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pw_merge_seq.sv
module pw_merge_seq
    import pwm_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int PAGE_BYTES   = 256,
    parameter int ERASE_CYCLES = 40,
    parameter int PROG_CYCLES  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_i,
    input  logic              cmd_start_i,
    input  logic              cmd_pp_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              cmd_end_i,
    output logic              wip_o,
    output logic              wel_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic              arr_rd_en_o,
    input  logic [7:0]        arr_rd_data_i,
    output logic              arr_erase_o,
    output logic              arr_wr_en_o,
    output logic [7:0]        arr_wr_data_o
);

    localparam int OFF_W   = $clog2(PAGE_BYTES);
    localparam int PG_W    = ADDR_W - OFF_W;
    localparam int CNT_W   = OFF_W + 1;
    localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        seq_st_e          st;
        logic [PG_W-1:0]  page;
        logic [OFF_W-1:0] off;
        logic             pp;
        logic             got;
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic [OFF_W-1:0] pidx;
        logic             wel;
    } seq_t;

    seq_t cur_q, cur_d;

    logic             buf_clr;
    logic             buf_hw_en;
    logic [7:0]       buf_rd_data;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             pp_mode_w;

    logic              rd_en_c, erase_c, wr_en_c;
    logic [ADDR_W-1:0] addr_c;

    pwm_page_buf #(.DEPTH(PAGE_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .hw_en_i   (buf_hw_en),
        .hw_idx_i  (cur_q.off),
        .hw_data_i (byte_i),
        .mw_en_i   (cur_q.pend),
        .mw_idx_i  (cur_q.pidx),
        .mw_data_i (arr_rd_data_i),
        .rd_idx_i  (cur_q.cnt[OFF_W-1:0]),
        .rd_data_o (buf_rd_data)
    );

    pwm_cycle_timer #(.W(TMR_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    always_comb begin
        cur_d     = cur_q;
        cur_d.pend = 1'b0;
        buf_clr   = 1'b0;
        buf_hw_en = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        rd_en_c   = 1'b0;
        erase_c   = 1'b0;
        wr_en_c   = 1'b0;
        addr_c    = {cur_q.page, cur_q.cnt[OFF_W-1:0]};

        case (cur_q.st)
            ST_IDLE: begin
                if (wren_i) cur_d.wel = 1'b1;
                if (cmd_start_i && cur_q.wel) begin
                    cur_d.st   = ST_FILL;
                    cur_d.page = cmd_addr_i[ADDR_W-1:OFF_W];
                    cur_d.off  = cmd_addr_i[OFF_W-1:0];
                    cur_d.pp   = cmd_pp_i;
                    cur_d.got  = 1'b0;
                    buf_clr    = 1'b1;
                end
            end
            ST_FILL: begin
                if (byte_vld_i) begin
                    buf_hw_en = 1'b1;
                    cur_d.off = cur_q.off + OFF_W'(1);
                    cur_d.got = 1'b1;
                end
                if (cmd_end_i) begin
                    cur_d.cnt = '0;
                    if (cur_q.got || byte_vld_i) begin
                        cur_d.st = cur_q.pp ? ST_PROG : ST_MERGE;
                    end else begin
                        cur_d.st = ST_IDLE;
                    end
                end
            end
            ST_MERGE: begin
                if (cur_q.cnt < LAST_CNT) begin
                    rd_en_c    = 1'b1;
                    cur_d.pend = 1'b1;
                    cur_d.pidx = cur_q.cnt[OFF_W-1:0];
                    cur_d.cnt  = cur_q.cnt + CNT_W'(1);
                end else begin
                    cur_d.st = ST_ERASE;
                end
            end
            ST_ERASE: begin
                erase_c  = 1'b1;
                addr_c   = {cur_q.page, {OFF_W{1'b0}}};
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(ERASE_CYCLES - 1);
                cur_d.st = ST_EWAIT;
            end
            ST_EWAIT: begin
                if (tmr_zero) begin
                    cur_d.st  = ST_PROG;
                    cur_d.cnt = '0;
                end
            end
            ST_PROG: begin
                if (cur_q.cnt < LAST_CNT) begin
                    wr_en_c   = 1'b1;
                    cur_d.cnt = cur_q.cnt + CNT_W'(1);
                end else begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(PROG_CYCLES - 1);
                    cur_d.st = ST_PWAIT;
                end
            end
            ST_PWAIT: begin
                if (tmr_zero) begin
                    cur_d.st  = ST_FINISH;
                    cur_d.wel = 1'b0;
                end
            end
            ST_FINISH: begin
                cur_d.st = ST_IDLE;
            end
            default: cur_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, default: '0};
        end else begin
            cur_q <= cur_d;
        end
    end

    assign wip_o = (cur_q.st == ST_MERGE) || (cur_q.st == ST_ERASE) ||
                   (cur_q.st == ST_EWAIT) || (cur_q.st == ST_PROG)  ||
                   (cur_q.st == ST_PWAIT);
    assign wel_o         = cur_q.wel;
    assign done_o        = (cur_q.st == ST_FINISH);
    assign arr_addr_o    = addr_c;
    assign arr_rd_en_o   = rd_en_c;
    assign arr_erase_o   = erase_c;
    assign arr_wr_en_o   = wr_en_c;
    assign arr_wr_data_o = buf_rd_data;
    assign pp_mode_w     = cur_q.pp;

endmodule

// File: rtl/pw_merge_seq_chk.sv
module pw_merge_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic wip,
    input logic wel,
    input logic done,
    input logic rd_en,
    input logic erase,
    input logic wr_en,
    input logic pp_mode
);

    AST_STROBE_IN_WIP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || erase || wr_en) |-> wip);                       // R8
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_en, erase, wr_en}));                         // R8
    AST_WIP_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> done);                                     // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                          // R9
    AST_DONE_NO_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wel && !wip));                                 // R9
    AST_PP_NO_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && pp_mode) |-> !(erase || rd_en));                  // R7
    AST_WIP_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> wel);                                      // R2

endmodule

bind pw_merge_seq pw_merge_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wip     (wip_o),
    .wel     (wel_o),
    .done    (done_o),
    .rd_en   (arr_rd_en_o),
    .erase   (arr_erase_o),
    .wr_en   (arr_wr_en_o),
    .pp_mode (pp_mode_w)
);

// File: tb/pw_merge_seq_tb.sv
`timescale 1ns/1ps
module pw_merge_seq_tb;

    localparam int E_CYC = 12;
    localparam int P_CYC = 8;
    localparam int PW_WIP = 2 * 257 + 1 + E_CYC + P_CYC;
    localparam int PP_WIP = 257 + P_CYC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wren = 1'b0, cmd_start = 1'b0, cmd_pp = 1'b0;
    logic [23:0] cmd_addr = '0;
    logic        byte_vld = 1'b0, cmd_end = 1'b0;
    logic [7:0]  byte_d = '0;
    logic        wip, wel, done;
    logic [23:0] arr_addr;
    logic        arr_rd_en, arr_erase, arr_wr_en;
    logic [7:0]  arr_rd_data = '0, arr_wr_data;

    always #2.5 clk = ~clk;

    pw_merge_seq #(.ERASE_CYCLES(E_CYC), .PROG_CYCLES(P_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wren_i(wren), .cmd_start_i(cmd_start),
        .cmd_pp_i(cmd_pp), .cmd_addr_i(cmd_addr), .byte_vld_i(byte_vld),
        .byte_i(byte_d), .cmd_end_i(cmd_end), .wip_o(wip), .wel_o(wel),
        .done_o(done), .arr_addr_o(arr_addr), .arr_rd_en_o(arr_rd_en),
        .arr_rd_data_i(arr_rd_data), .arr_erase_o(arr_erase),
        .arr_wr_en_o(arr_wr_en), .arr_wr_data_o(arr_wr_data)
    );

    logic [7:0] mem_m [1024];
    logic [7:0] exp_m [1024];
    logic [7:0] tx    [300];
    int checks = 0, errors = 0;
    int n_rd = 0, n_er = 0, n_wr = 0, n_wip = 0;

    // Array model: erase sets a page to ones, program ANDs, read has one cycle latency.
    always @(posedge clk) begin
        if (arr_erase)
            for (int j = 0; j < 256; j++) mem_m[{arr_addr[9:8], 8'(j)}] <= 8'hFF;
        if (arr_wr_en) mem_m[arr_addr[9:0]] <= mem_m[arr_addr[9:0]] & arr_wr_data;
        if (arr_rd_en) arr_rd_data <= mem_m[arr_addr[9:0]];
        if (rst_n) begin
            if (arr_rd_en) n_rd++;
            if (arr_erase) n_er++;
            if (arr_wr_en) n_wr++;
            if (wip)       n_wip++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic clr_cnt;
        n_rd = 0; n_er = 0; n_wr = 0; n_wip = 0;
    endtask

    task automatic cmp_page(input int pg, input string req);
        int bad = 0, first = -1;
        for (int i = 0; i < 256; i++)
            if (mem_m[pg*256+i] !== exp_m[pg*256+i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (first < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, mem_m[pg*256+first], exp_m[pg*256+first]);
    endtask

    // Expected page update built from R3/R5/R6/R7.
    task automatic apply_exp(input bit pp, input logic [23:0] a, input int n);
        logic [7:0] bv [256];
        bit         bf [256];
        for (int i = 0; i < 256; i++) bf[i] = 1'b0;
        for (int k = 0; k < n; k++) begin
            bv[(a[7:0] + k) % 256] = tx[k];
            bf[(a[7:0] + k) % 256] = 1'b1;
        end
        for (int i = 0; i < 256; i++)
            if (bf[i]) begin
                if (pp) exp_m[a[9:8]*256+i] = exp_m[a[9:8]*256+i] & bv[i];
                else    exp_m[a[9:8]*256+i] = bv[i];
            end
    endtask

    task automatic do_wren;
        wren = 1'b1; @(negedge clk); wren = 1'b0;
    endtask

    task automatic run_cmd(input bit pp, input logic [23:0] a, input int n, input bit joint);
        cmd_start = 1'b1; cmd_pp = pp; cmd_addr = a;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            byte_vld = 1'b1; byte_d = tx[k];
            if (joint && k == n - 1) cmd_end = 1'b1;
            @(negedge clk);
        end
        byte_vld = 1'b0;
        if (!joint || n == 0) begin
            cmd_end = 1'b1; @(negedge clk);
        end
        cmd_end = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (done !== 1'b1 && t < 4000) begin @(negedge clk); t++; end
        chk(done === 1'b1, {req, " done seen"}, done, 1);
        chk(wip === 1'b0 && wel === 1'b0, "R9 wip/wel low at done", {wip, wel}, 0);
        @(negedge clk);
        chk(done === 1'b0, "R9 done single pulse", done, 0);
    endtask

    task automatic t_reset;
        chk(wip === 1'b0 && wel === 1'b0 && done === 1'b0, "R1 reset outputs", {wip, wel, done}, 0);
        chk(n_rd + n_er + n_wr == 0, "R1 no strobes", n_rd + n_er + n_wr, 0);
    endtask

    task automatic t_no_wel;
        clr_cnt();
        tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33;
        run_cmd(1'b0, 24'h000005, 3, 1'b0);
        repeat (20) @(negedge clk);
        chk(n_wip == 0, "R2 command without wel ignored", n_wip, 0);
        cmp_page(0, "R2 page untouched");
    endtask

    task automatic t_pw_merge;
        do_wren();
        chk(wel === 1'b1, "R2 wel set", wel, 1);
        clr_cnt();
        tx[0] = 8'hFF; tx[1] = 8'h00; tx[2] = 8'hA5; tx[3] = 8'h5A; tx[4] = 8'hFF; tx[5] = 8'h81;
        run_cmd(1'b0, 24'h000110, 6, 1'b0);
        chk(wip === 1'b1, "R8 wip after end", wip, 1);
        wait_done("R6");
        apply_exp(1'b0, 24'h000110, 6);
        cmp_page(1, "R5 R6 rewrite merge");
        chk(n_rd == 256, "R5 merge reads", n_rd, 256);
        chk(n_er == 1 && n_wr == 256, "R6 erase then program", n_er * 1000 + n_wr, 1256);
        chk(n_wip == PW_WIP, "R8 rewrite busy length", n_wip, PW_WIP);
    endtask

    task automatic t_wrap;
        do_wren();
        for (int k = 0; k < 5; k++) tx[k] = 8'(8'hC0 + k);
        run_cmd(1'b0, 24'h0002FE, 5, 1'b0);
        wait_done("R3");
        apply_exp(1'b0, 24'h0002FE, 5);
        cmp_page(2, "R3 offset wrap");
        do_wren();
        for (int k = 0; k < 258; k++) tx[k] = 8'(k * 3 + 1);
        run_cmd(1'b0, 24'h000300, 258, 1'b0);
        wait_done("R3");
        apply_exp(1'b0, 24'h000300, 258);
        cmp_page(3, "R3 later byte overwrites");
        chk(exp_m[768] == 8'(256 * 3 + 1), "R3 expectation self check", exp_m[768], 8'(769));
    endtask

    task automatic t_pp;
        do_wren();
        clr_cnt();
        tx[0] = 8'hF0; tx[1] = 8'h0F; tx[2] = 8'hFF; tx[3] = 8'h3C;
        run_cmd(1'b1, 24'h000140, 4, 1'b0);
        chk(wip === 1'b1, "R8 wip after end (pp)", wip, 1);
        wait_done("R7");
        apply_exp(1'b1, 24'h000140, 4);
        cmp_page(1, "R7 program-only AND");
        chk(n_er == 0 && n_rd == 0, "R7 no erase no read", n_er + n_rd, 0);
        chk(n_wip == PP_WIP, "R8 program-only busy length", n_wip, PP_WIP);
    endtask

    task automatic t_empty;
        do_wren();
        clr_cnt();
        run_cmd(1'b0, 24'h000200, 0, 1'b0);
        repeat (10) @(negedge clk);
        chk(n_wip == 0 && n_er + n_wr == 0, "R4 empty command no cycle", n_wip, 0);
        chk(wel === 1'b1, "R4 wel kept", wel, 1);
    endtask

    task automatic t_joint;
        tx[0] = 8'h12; tx[1] = 8'h34; tx[2] = 8'h56;
        run_cmd(1'b0, 24'h000080, 3, 1'b1);
        chk(wip === 1'b1, "R10 cycle starts with joint end", wip, 1);
        wait_done("R10");
        apply_exp(1'b0, 24'h000080, 3);
        cmp_page(0, "R10 last byte with end included");
    endtask

    task automatic t_ignore;
        clr_cnt();
        byte_vld = 1'b1; byte_d = 8'h00;
        repeat (3) @(negedge clk);
        byte_vld = 1'b0;
        chk(n_wip == 0, "R11 idle bytes no cycle", n_wip, 0);
        do_wren();
        tx[0] = 8'h77; tx[1] = 8'h88;
        run_cmd(1'b0, 24'h000210, 2, 1'b0);
        repeat (10) begin
            byte_vld = 1'b1; byte_d = 8'h00; cmd_start = 1'b1; cmd_addr = 24'h000220; wren = 1'b1;
            @(negedge clk);
        end
        byte_vld = 1'b0; cmd_start = 1'b0; wren = 1'b0;
        wait_done("R11");
        apply_exp(1'b0, 24'h000210, 2);
        cmp_page(2, "R11 busy traffic ignored");
        repeat (5) @(negedge clk);
        chk(wel === 1'b0 && wip === 1'b0, "R11 wren while busy ignored", {wel, wip}, 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem_m[i] = 8'(i * 7 + 3);
            exp_m[i] = 8'(i * 7 + 3);
        end
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_wel();
        t_pw_merge();
        t_wrap();
        t_pp();
        t_empty();
        t_joint();
        t_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule